// File: doc/BRIEF.md
# E1 Signalling and CRC-4 Multiframe Aligner

This block runs downstream of a basic E1 frame aligner. Once per received frame it takes the frame-aligned timeslot 0 and timeslot 16 octets, a strobe that marks the frame, and a flag that tells it whether the frame carries the frame alignment word or the non-alignment word. From this stream it builds two multiframe alignments that are independent of each other. Each one has a 16-frame structure.

The signalling alignment locks onto the first all-zero upper nibble of timeslot 16. After lock, that nibble is checked only in frame 0 of each multiframe. The CRC-4 alignment collects bit 1 of each non-alignment word and looks for the six-bit marker. It declares lock only when two markers arrive exactly one multiframe apart, inside a search window of 64 frames (8 ms). For each alignment the block drives an active-low sync flag and the number of the most recent frame within the multiframe. Both searches are held in reset while basic frame alignment is absent.

Top module: `e1_mf_aligner`

## Requirements
- R1: While bfa_i is low at a clock edge, both sync flags are high and both frame counters are 0 after that edge, whatever the frame inputs carry.
- R2: With bfa_i high and frame_valid_i low, no output changes. Only frames marked by frame_valid_i advance either aligner.
- R3: While searching, the first valid frame with ts16_i[7:4] equal to 0000 sets sig_sync_no low and sig_frame_o to 0 at that edge.
- R4: While in signalling sync, sig_frame_o steps by one modulo 16 on every valid frame.
- R5: While in signalling sync, a nonzero ts16_i[7:4] in frames 1 to 15 has no effect on sync or on the counter.
- R6: A nonzero nibble in frame 0 is counted as an error. The second consecutive errored frame 0 sets sig_sync_no high and sig_frame_o to 0. A correct frame 0 clears the error count.
- R7: The CRC-4 search samples only ts0_i[7] (bit position 1), and only in frames with fas_frame_i low. The marker is 0,0,1,0,1,1 in order of arrival. Bit 7 of alignment-word frames is ignored.
- R8: The CRC-4 lock needs a second marker ending exactly 16 frames after a first one. At the edge of the second marker, crc_sync_no goes low and crc_frame_o becomes 11. A single marker, or two markers at any other spacing, gives no lock.
- R9: The CRC-4 search window is 64 valid frames from the start of the search. If no lock occurs within it, the pending marker and the collected bits are discarded and a new window starts.
- R10: Once in CRC-4 sync, crc_frame_o steps by one modulo 16 on every valid frame. Sync holds, whatever later bits arrive, until bfa_i falls.
- R11: The two alignments are independent. One can be in sync while the other keeps searching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bfa_i | input | 1 | Basic frame alignment held |
| frame_valid_i | input | 1 | One-cycle strobe per received frame |
| fas_frame_i | input | 1 | 1: frame carries the alignment word; 0: the non-alignment word |
| ts0_i | input | 8 | Timeslot 0 octet, bit 7 is bit position 1 |
| ts16_i | input | 8 | Timeslot 16 octet, bits 7:4 hold the multiframe nibble |
| sig_sync_no | output | 1 | Signalling multiframe sync, active low |
| sig_frame_o | output | 4 | Frame number within the signalling multiframe |
| crc_sync_no | output | 1 | CRC-4 multiframe sync, active low |
| crc_frame_o | output | 4 | Frame number within the CRC-4 multiframe |

## Verification
Some properties are checked on every cycle. A lost basic alignment clears both aligners. Idle cycles leave everything unchanged. Each lock lands on its fixed frame number (0 for signalling, 11 for CRC-4). Locked counters step modulo 16. A loss of signalling sync can only follow an errored frame 0 or a drop of basic alignment.

Other behaviour needs the bench's frame sequences. These cover the two-consecutive-error rule and how a good frame 0 resets it. They cover the 16-frame spacing between CRC-4 markers and the discarding of a marker pair split by the 64-frame window, which a per-cycle property cannot see.

// File: rtl/e1_mfa_pkg.sv
package e1_mfa_pkg;
  localparam int unsigned FRAME_W    = 4;         // 16-frame multiframe
  localparam int unsigned SIG_ERRS   = 2;         // consecutive bad frame 0 to lose
  localparam int unsigned CRC_PAT_W  = 6;
  localparam logic [5:0]  CRC_PAT    = 6'b001011; // oldest bit in MSB
  localparam int unsigned CRC_LOCKF  = 11;        // frame holding the last marker bit
  localparam int unsigned CRC_WINDOW = 64;        // 8 ms at 125 us per frame
endpackage

// File: rtl/mfa_sig_align.sv
module mfa_sig_align #(
  parameter int unsigned FRAME_W  = 4,
  parameter int unsigned ERR_LIM  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bfa_i,
  input  logic               frame_valid_i,
  input  logic [3:0]         nib_i,
  output logic               sync_no,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int unsigned ERR_W = $clog2(ERR_LIM + 1);

  logic               locked_q;
  logic [FRAME_W-1:0] cnt_q, cnt_nxt;
  logic [ERR_W-1:0]   err_q;
  logic               nib_ok, at_f0, err_last;

  always_comb begin
    cnt_nxt  = cnt_q + 1'b1;
    at_f0    = (cnt_nxt == '0);
    nib_ok   = (nib_i == 4'h0);
    err_last = (err_q == ERR_W'(ERR_LIM - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      cnt_q    <= '0;
      err_q    <= '0;
    end else if (!bfa_i) begin
      locked_q <= 1'b0;
      cnt_q    <= '0;
      err_q    <= '0;
    end else if (frame_valid_i) begin
      if (!locked_q) begin
        if (nib_ok) begin
          locked_q <= 1'b1;
          cnt_q    <= '0;
          err_q    <= '0;
        end
      end else if (at_f0 && !nib_ok && err_last) begin
        locked_q <= 1'b0;
        cnt_q    <= '0;
        err_q    <= '0;
      end else begin
        cnt_q <= cnt_nxt;
        if (at_f0) err_q <= nib_ok ? '0 : err_q + 1'b1;
      end
    end
  end

  assign sync_no = ~locked_q;
  assign frame_o = cnt_q;
endmodule

// File: rtl/mfa_crc_align.sv
module mfa_crc_align #(
  parameter int unsigned FRAME_W = 4,
  parameter int unsigned PAT_W   = 6,
  parameter logic [PAT_W-1:0] PAT = 6'b001011,
  parameter int unsigned LOCKF   = 11,
  parameter int unsigned WINDOW  = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bfa_i,
  input  logic               frame_valid_i,
  input  logic               nfas_i,
  input  logic               bit_i,
  output logic               sync_no,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int unsigned WIN_W = $clog2(WINDOW);
  localparam logic [FRAME_W-1:0] SPAN_LAST = '1;  // 16 frames between markers

  logic               locked_q, cand_q;
  logic [FRAME_W-1:0] cnt_q, dist_q;
  logic [PAT_W-1:0]   sh_q, sh_nxt;
  logic [WIN_W-1:0]   win_q;
  logic               hit, pair, win_end;

  always_comb begin
    sh_nxt  = nfas_i ? {sh_q[PAT_W-2:0], bit_i} : sh_q;
    hit     = nfas_i && (sh_nxt == PAT);
    pair    = hit && cand_q && (dist_q == SPAN_LAST);
    win_end = (win_q == WIN_W'(WINDOW - 1));
  end

  // Shift register preset to ones: pattern leads with zeros, so no early false hit.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      cand_q   <= 1'b0;
      cnt_q    <= '0;
      dist_q   <= '0;
      sh_q     <= '1;
      win_q    <= '0;
    end else if (!bfa_i) begin
      locked_q <= 1'b0;
      cand_q   <= 1'b0;
      cnt_q    <= '0;
      dist_q   <= '0;
      sh_q     <= '1;
      win_q    <= '0;
    end else if (frame_valid_i) begin
      if (locked_q) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (pair) begin
        locked_q <= 1'b1;
        cnt_q    <= FRAME_W'(LOCKF);
      end else if (win_end) begin
        cand_q <= 1'b0;
        dist_q <= '0;
        sh_q   <= '1;
        win_q  <= '0;
      end else begin
        sh_q  <= sh_nxt;
        win_q <= win_q + 1'b1;
        if (hit) begin
          cand_q <= 1'b1;
          dist_q <= '0;
        end else if (cand_q) begin
          if (dist_q == SPAN_LAST) cand_q <= 1'b0;
          else                     dist_q <= dist_q + 1'b1;
        end
      end
    end
  end

  assign sync_no = ~locked_q;
  assign frame_o = cnt_q;
endmodule

// File: rtl/e1_mf_aligner.sv
module e1_mf_aligner
  import e1_mfa_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bfa_i,
  input  logic               frame_valid_i,
  input  logic               fas_frame_i,
  input  logic [7:0]         ts0_i,
  input  logic [7:0]         ts16_i,
  output logic               sig_sync_no,
  output logic [FRAME_W-1:0] sig_frame_o,
  output logic               crc_sync_no,
  output logic [FRAME_W-1:0] crc_frame_o
);
  logic unused_bits;
  assign unused_bits = ^{ts0_i[6:0], ts16_i[3:0]};

  mfa_sig_align #(
    .FRAME_W (FRAME_W),
    .ERR_LIM (SIG_ERRS)
  ) u_sig (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bfa_i         (bfa_i),
    .frame_valid_i (frame_valid_i),
    .nib_i         (ts16_i[7:4]),
    .sync_no       (sig_sync_no),
    .frame_o       (sig_frame_o)
  );

  mfa_crc_align #(
    .FRAME_W (FRAME_W),
    .PAT_W   (CRC_PAT_W),
    .PAT     (CRC_PAT),
    .LOCKF   (CRC_LOCKF),
    .WINDOW  (CRC_WINDOW)
  ) u_crc (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bfa_i         (bfa_i),
    .frame_valid_i (frame_valid_i),
    .nfas_i        (~fas_frame_i),
    .bit_i         (ts0_i[7]),
    .sync_no       (crc_sync_no),
    .frame_o       (crc_frame_o)
  );
endmodule

// File: rtl/e1_mf_aligner_chk.sv
module e1_mf_aligner_chk
  import e1_mfa_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bfa_i,
  input logic               frame_valid_i,
  input logic [3:0]         nib_i,
  input logic               sig_sync_no,
  input logic [FRAME_W-1:0] sig_frame_o,
  input logic               crc_sync_no,
  input logic [FRAME_W-1:0] crc_frame_o
);
  a_r1_bfa_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bfa_i |=> sig_sync_no && crc_sync_no && sig_frame_o == '0 && crc_frame_o == '0);

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bfa_i && !frame_valid_i |=> $stable(sig_sync_no) && $stable(sig_frame_o)
                                && $stable(crc_sync_no) && $stable(crc_frame_o));

  a_r3_lock_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sig_sync_no) |-> sig_frame_o == '0 && $past(nib_i) == 4'h0);

  a_r4_sig_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bfa_i && frame_valid_i && !sig_sync_no
      |=> sig_sync_no || sig_frame_o == FRAME_W'($past(sig_frame_o) + 1'b1));

  a_r6_loss_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sig_sync_no) |-> $past(!bfa_i) ||
      ($past(frame_valid_i) && $past(nib_i) != 4'h0 && $past(sig_frame_o) == '1));

  a_r8_crc_lock_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(crc_sync_no) |-> crc_frame_o == FRAME_W'(CRC_LOCKF));

  a_r10_crc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bfa_i && frame_valid_i && !crc_sync_no
      |=> !crc_sync_no && crc_frame_o == FRAME_W'($past(crc_frame_o) + 1'b1));

  a_r10_crc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_sync_no) |-> $past(!bfa_i));
endmodule

bind e1_mf_aligner e1_mf_aligner_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bfa_i         (bfa_i),
  .frame_valid_i (frame_valid_i),
  .nib_i         (ts16_i[7:4]),
  .sig_sync_no   (sig_sync_no),
  .sig_frame_o   (sig_frame_o),
  .crc_sync_no   (crc_sync_no),
  .crc_frame_o   (crc_frame_o)
);

// File: tb/e1_mf_aligner_bench.sv
module e1_mf_aligner_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bfa_i = 1'b0;
  logic       frame_valid_i = 1'b0;
  logic       fas_frame_i = 1'b1;
  logic [7:0] ts0_i = 8'h00;
  logic [7:0] ts16_i = 8'hFF;
  logic       sig_sync_no, crc_sync_no;
  logic [3:0] sig_frame_o, crc_frame_o;

  int n_chk = 0;
  int n_fail = 0;
  int pos = 0;

  localparam logic [5:0] MARK = 6'b001011;

  typedef struct packed {
    logic [3:0] nib;
    logic       exp_sync_n;
  } sig_vec_t;

  // frame-0 nibble per multiframe and expected flag after it
  localparam sig_vec_t SIG_TAB [6] = '{
    '{4'h0, 1'b0},   // R3 initial lock
    '{4'h3, 1'b0},   // R6 first error, sync kept
    '{4'h0, 1'b0},   // R6 good frame 0 clears count
    '{4'h9, 1'b0},   // R6 error again, count restarted
    '{4'h1, 1'b1},   // R6 second consecutive error, sync lost
    '{4'h0, 1'b0}    // R3 re-lock
  };

  always #10 clk_i = ~clk_i;

  e1_mf_aligner u_e1_mf_aligner (
    .clk_i, .rst_ni, .bfa_i, .frame_valid_i, .fas_frame_i, .ts0_i, .ts16_i,
    .sig_sync_no, .sig_frame_o, .crc_sync_no, .crc_frame_o
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic fas, input logic [7:0] t0, input logic [7:0] t16);
    @(negedge clk_i);
    fas_frame_i = fas; ts0_i = t0; ts16_i = t16; frame_valid_i = 1'b1;
    @(negedge clk_i);
    frame_valid_i = 1'b0;
  endtask

  // CRC-4 stream; bad flips the marker bit of frame 5
  task automatic tx_crc(input int n, input bit bad);
    for (int i = 0; i < n; i++) begin
      logic b;
      if (pos % 2 == 1) begin
        b = (pos <= 11) ? MARK[5 - (pos - 1) / 2] : 1'b1;
        if (bad && pos == 5) b = ~b;
        send(1'b0, {b, 7'h40}, 8'hFF);
      end else begin
        send(1'b1, 8'h9B, 8'hFF);  // R7 bit 7 of alignment word set, must be ignored
      end
      pos = (pos + 1) % 16;
    end
  endtask

  task automatic restart_bfa();
    @(negedge clk_i); bfa_i = 1'b0;
    @(negedge clk_i); bfa_i = 1'b1;
    pos = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset sig_sync", {7'd0, sig_sync_no}, 8'd1);
    chk("R1 reset crc_sync", {7'd0, crc_sync_no}, 8'd1);
    chk("R1 reset frames", {sig_frame_o, crc_frame_o}, 8'h00);

    send(1'b1, 8'h1B, 8'h00);
    chk("R1 no lock without bfa", {7'd0, sig_sync_no}, 8'd1);

    bfa_i = 1'b1;
    foreach (SIG_TAB[r]) begin
      send(1'b1, 8'h1B, {SIG_TAB[r].nib, 4'h0});
      chk("R6 R3 flag after frame 0", {7'd0, sig_sync_no}, {7'd0, SIG_TAB[r].exp_sync_n});
      chk("R3 R6 counter after frame 0", {4'd0, sig_frame_o}, 8'd0);
      for (int k = 1; k < 16; k++) begin
        send(k[0] ? 1'b0 : 1'b1, 8'h40, 8'hA0);  // R5 nonzero nibble away from frame 0
        chk("R5 flag", {7'd0, sig_sync_no}, {7'd0, SIG_TAB[r].exp_sync_n});
        chk("R4 counter", {4'd0, sig_frame_o}, SIG_TAB[r].exp_sync_n ? 8'd0 : 8'(k));
      end
    end

    repeat (6) @(negedge clk_i);
    chk("R2 idle counter", {4'd0, sig_frame_o}, 8'd15);
    chk("R2 idle flag", {7'd0, sig_sync_no}, 8'd0);
    send(1'b1, 8'h1B, 8'h00);
    chk("R4 wrap to 0", {4'd0, sig_frame_o}, 8'd0);

    restart_bfa();
    chk("R1 bfa drop sig", {3'd0, sig_sync_no, sig_frame_o}, 8'h10);

    // CRC A: lock on second marker 16 frames later
    tx_crc(16, 1'b0);
    chk("R8 one marker no lock", {7'd0, crc_sync_no}, 8'd1);
    tx_crc(12, 1'b0);
    chk("R8 lock flag", {7'd0, crc_sync_no}, 8'd0);
    chk("R8 lock frame 11", {4'd0, crc_frame_o}, 8'd11);
    chk("R11 sig still searching", {7'd0, sig_sync_no}, 8'd1);
    tx_crc(4, 1'b0);
    chk("R10 count to 15", {4'd0, crc_frame_o}, 8'd15);
    repeat (5) @(negedge clk_i);
    chk("R2 crc idle", {3'd0, crc_sync_no, crc_frame_o}, 8'h0F);
    tx_crc(16, 1'b1);
    chk("R10 sync kept on bad marker", {3'd0, crc_sync_no, crc_frame_o}, 8'h0F);
    tx_crc(1, 1'b0);
    chk("R10 wrap", {4'd0, crc_frame_o}, 8'd0);

    restart_bfa();
    chk("R1 bfa drop crc", {3'd0, crc_sync_no, crc_frame_o}, 8'h10);

    // CRC B: markers 32 apart do not lock, next pair does
    tx_crc(16, 1'b0);
    tx_crc(16, 1'b1);
    tx_crc(16, 1'b0);
    chk("R8 spacing 32 no lock", {7'd0, crc_sync_no}, 8'd1);
    tx_crc(16, 1'b0);
    chk("R8 R7 relock", {3'd0, crc_sync_no, crc_frame_o}, 8'h0F);

    // CRC C: pair split by the window end is discarded
    restart_bfa();
    tx_crc(48, 1'b1);
    tx_crc(16, 1'b0);
    chk("R9 first marker only", {7'd0, crc_sync_no}, 8'd1);
    tx_crc(16, 1'b0);
    chk("R9 window drops pair", {7'd0, crc_sync_no}, 8'd1);
    tx_crc(16, 1'b0);
    chk("R9 lock in new window", {3'd0, crc_sync_no, crc_frame_o}, 8'h0F);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule